// File: doc/BRIEF.md
# Programmable Up-Count Interval Timer

This block is a timer peripheral with three registers reached over a small register bus: a count value, a limit value and a control word. While its run bit is set, the count steps up by one on every clock. When the count equals the limit, the next step takes it back to zero. That wrap can latch an interrupt-pending flag. The flag drives a level interrupt line until software writes the control register.

Software sets up an interval in three writes: the limit, then a count of zero, then the control word. It services an interrupt by rewriting the control word. If interrupt enable is rewritten as 1, the timer keeps firing every limit+1 cycles (periodic use). If it is rewritten as 0, no further interrupt is raised (one-shot use). With the limit at all-ones and interrupt enable off, the block is a free-running counter that wraps through zero.

Top module: `ivt_timer`

## Requirements
- R1: After reset, count reads 0, limit reads all-ones, the control word reads 0 and irq is 0.
- R2: A bus write to address 0 loads count with the write data. A count write in a cycle where the counter would also step takes priority over the step.
- R3: While control bit 1 (run) is 1, count increases by exactly 1 per clock. While it is 0, count holds its value.
- R4: When count equals limit on a running clock, the next count is 0. From a start of 0, wrap events are therefore limit+1 clocks apart.
- R5: Control bit 3 (pending) is set on a wrap event only while control bit 0 (interrupt enable) is 1. A wrap with interrupt enable at 0 leaves pending at 0.
- R6: Every write to the control register (address 2) clears pending and loads only bits 0 and 1 from the write data. Bit 3 of the write data is ignored, and bits 2 and 31:4 always read 0.
- R7: irq is high exactly when pending and interrupt enable are both 1, and it stays high with no bus activity until a control write.
- R8: The register map is: address 0 count, address 1 limit, address 2 control, address 3 reads 0. The read data is registered and shows the register as it stood at the clock edge where bus_re was sampled high.
- R9: With limit all-ones, count passes from all-ones to 0 and keeps counting.
- R10: If a control write and a wrap event with interrupt enable fall in the same clock, the write wins and pending ends at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the timer with its default 32-bit count and 2-bit address. It then programs small limits such as 4, 7 and 20, so wraps, periodic interrupt spacing and a write landing in the same clock as a wrap all happen within tens of cycles. Loading count just below all-ones with the limit at all-ones reaches the natural 32-bit overflow in a handful of clocks. No narrower build is needed for that.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  typedef enum logic [1:0] {
    REG_COUNT = 2'd0,
    REG_LIMIT = 2'd1,
    REG_CTRL  = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_IE_BIT   = 0;
  localparam int unsigned CTRL_RUN_BIT  = 1;
  localparam int unsigned CTRL_PEND_BIT = 3;
endpackage

// File: rtl/ivt_busdec.sv
module ivt_busdec #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic [DATA_W-1:0] limit_i,
  input  logic [DATA_W-1:0] ctrl_i,
  output logic              wr_count_o,
  output logic              wr_limit_o,
  output logic              wr_ctrl_o,
  output logic [DATA_W-1:0] rdata_o
);
  import ivt_pkg::*;

  logic sel_count, sel_limit, sel_ctrl;

  assign sel_count = (addr_i == ADDR_W'(REG_COUNT));
  assign sel_limit = (addr_i == ADDR_W'(REG_LIMIT));
  assign sel_ctrl  = (addr_i == ADDR_W'(REG_CTRL));

  assign wr_count_o = we_i & sel_count;
  assign wr_limit_o = we_i & sel_limit;
  assign wr_ctrl_o  = we_i & sel_ctrl;

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (sel_count) rd_mux = count_i;
    if (sel_limit) rd_mux = limit_i;
    if (sel_ctrl)  rd_mux = ctrl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
  end

  // R8: a read with no strobe leaves the returned word untouched
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             load_i,
  input  logic             limit_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] limit_o,
  output logic             wrap_o
);
  function automatic logic at_limit(input logic [CNT_W-1:0] cur,
                                    input logic [CNT_W-1:0] lim);
    return cur == lim;
  endfunction

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic [CNT_W-1:0] lim);
    return at_limit(cur, lim) ? '0 : cur + CNT_W'(1);
  endfunction

  logic hit;
  assign hit    = at_limit(count_o, limit_o);
  assign wrap_o = run_i & ~load_i & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count_o <= '0;
    else if (load_i)     count_o <= wdata_i;
    else if (run_i)      count_o <= step(count_o, limit_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          limit_o <= '1;
    else if (limit_wr_i) limit_o <= wdata_i;
  end

  p_load_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> count_o == $past(wdata_i));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && !hit) |=> count_o == $past(count_o) + CNT_W'(1));

  p_halted_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i) |=> $stable(count_o));

  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> count_o == '0);
endmodule

// File: rtl/ivt_ctrl.sv
module ivt_ctrl #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wrap_i,
  output logic              run_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] view_o
);
  import ivt_pkg::*;

  logic ie_q, run_q, pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      run_q <= 1'b0;
    end else if (wr_i) begin
      ie_q  <= wdata_i[CTRL_IE_BIT];
      run_q <= wdata_i[CTRL_RUN_BIT];
    end
  end

  // a control write acknowledges; it outranks a same-cycle wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pend_q <= 1'b0;
    else if (wr_i)           pend_q <= 1'b0;
    else if (wrap_i && ie_q) pend_q <= 1'b1;
  end

  assign run_o = run_q;
  assign irq_o = pend_q & ie_q;

  always_comb begin
    view_o                = '0;
    view_o[CTRL_IE_BIT]   = ie_q;
    view_o[CTRL_RUN_BIT]  = run_q;
    view_o[CTRL_PEND_BIT] = pend_q;
  end

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> !pend_q);

  p_ack_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wrap_i && ie_q) |=> !irq_o);

  p_wrap_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && ie_q && !wr_i) |=> pend_q);

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !(wrap_i && ie_q)) |=> !pend_q);

  p_irq_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !wr_i) |=> irq_o);
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic              wr_count, wr_limit, wr_ctrl;
  logic              run, wrap_evt;
  logic [DATA_W-1:0] count_q, limit_q, ctrl_view;

  ivt_busdec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_busdec (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (bus_addr),
    .we_i       (bus_we),
    .re_i       (bus_re),
    .count_i    (count_q),
    .limit_i    (limit_q),
    .ctrl_i     (ctrl_view),
    .wr_count_o (wr_count),
    .wr_limit_o (wr_limit),
    .wr_ctrl_o  (wr_ctrl),
    .rdata_o    (bus_rdata)
  );

  ivt_counter #(.CNT_W(DATA_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .load_i     (wr_count),
    .limit_wr_i (wr_limit),
    .wdata_i    (bus_wdata),
    .count_o    (count_q),
    .limit_o    (limit_q),
    .wrap_o     (wrap_evt)
  );

  ivt_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_ctrl),
    .wdata_i (bus_wdata),
    .wrap_i  (wrap_evt),
    .run_o   (run),
    .irq_o   (irq),
    .view_o  (ctrl_view)
  );
endmodule

// File: tb/ivt_timer_tb.sv
`timescale 1ns/1ps
module ivt_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0, errors = 0;
  longint cyc = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ivt_timer u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                   .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // driver: each call occupies exactly one rising edge
  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  // k idle cycles between a start and a stop write give k+1 counting edges
  task automatic run_for(int k);
    wr(2'd2, 32'h2);
    repeat (k) @(negedge clk);
    wr(2'd2, 32'h0);
  endtask

  // monitor: pop one expectation per sampled read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (bus_re) begin
        @(negedge clk);
        if (exp_q.size() == 0) check("R8 unexpected read", 32'h1, 32'h0);
        else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    longint t_prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R8 reset state and map
    check("R1 irq after reset", {31'd0, irq}, 32'h0);
    rd(2'd0, 32'h0, "R1 count reset");
    rd(2'd1, 32'hFFFF_FFFF, "R1 limit reset");
    rd(2'd2, 32'h0, "R1 ctrl reset");
    rd(2'd3, 32'h0, "R8 unused address");

    // R2 load, R3 count and halt
    wr(2'd1, 32'd1000);
    wr(2'd0, 32'd100);
    rd(2'd0, 32'd100, "R2 count load");
    rd(2'd1, 32'd1000, "R8 limit readback");
    run_for(9);
    rd(2'd0, 32'd110, "R3 ten increments");
    repeat (5) @(negedge clk);
    rd(2'd0, 32'd110, "R3 halted hold");

    // R4 wrap, R5 no pending with ie off
    wr(2'd1, 32'd20);
    wr(2'd0, 32'd15);
    run_for(9);
    rd(2'd0, 32'd4, "R4 wrap through zero");
    rd(2'd2, 32'h0, "R5 no pending when ie off");
    check("R5 irq quiet", {31'd0, irq}, 32'h0);

    // R2 write priority while running
    wr(2'd1, 32'd1000);
    wr(2'd0, 32'd0);
    wr(2'd2, 32'h2);
    repeat (2) @(negedge clk);
    wr(2'd0, 32'd500);
    wr(2'd2, 32'h0);
    rd(2'd0, 32'd501, "R2 write beats increment");

    // R6 control write masks and clears
    wr(2'd0, 32'd0);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, 32'h3, "R6 only bits 0 and 1 writable");
    wr(2'd2, 32'h0);

    // R4 R5 R7 periodic interrupts
    wr(2'd1, 32'd7);
    wr(2'd0, 32'd0);
    wr(2'd2, 32'h3);
    t_prev = cyc;
    while (!irq) @(negedge clk);
    check("R4 first interval", 32'(cyc - t_prev), 32'd8);
    t_prev = cyc;
    repeat (3) @(negedge clk);
    check("R7 irq held until ack", {31'd0, irq}, 32'h1);
    rd(2'd2, 32'hB, "R5 pending bit 3 set");
    wr(2'd2, 32'h3);
    check("R6 ack drops irq", {31'd0, irq}, 32'h0);
    for (int i = 0; i < 3; i++) begin
      while (!irq) @(negedge clk);
      check("R4 periodic spacing limit+1", 32'(cyc - t_prev), 32'd8);
      t_prev = cyc;
      wr(2'd2, 32'h3);
    end

    // R5 R7 one-shot: acknowledge with ie off
    while (!irq) @(negedge clk);
    wr(2'd2, 32'h2);
    repeat (20) @(negedge clk);
    check("R7 one-shot stays quiet", {31'd0, irq}, 32'h0);
    rd(2'd2, 32'h2, "R5 no pending after ie off");
    wr(2'd2, 32'h0);

    // R10 ack and wrap in the same clock
    wr(2'd1, 32'd4);
    wr(2'd0, 32'd0);
    wr(2'd2, 32'h3);
    repeat (4) @(negedge clk);
    wr(2'd2, 32'h3);
    check("R10 ack wins over wrap", {31'd0, irq}, 32'h0);
    rd(2'd2, 32'h3, "R10 pending clear");
    wr(2'd2, 32'h0);

    // R9 free-running overflow
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, 32'hFFFF_FFFD);
    run_for(4);
    rd(2'd0, 32'd2, "R9 free-run wraps to zero");
    check("R9 irq quiet", {31'd0, irq}, 32'h0);

    repeat (3) @(negedge clk);
    check("R8 all reads returned", 32'(exp_q.size()), 32'd0);
    summary();
    $finish;
  end
endmodule